// File: doc/BRIEF.md
# Line APS Byte and K2 Alarm Monitor

This block sits behind a line-overhead extractor and acts once per received frame. On each frame strobe it takes the K1 and K2 automatic protection switching bytes and applies a persistence filter to the pair. A pair becomes valid only after it repeats unchanged over several frames. The filtered pair is kept in output registers. When a newly accepted pair differs from the stored one, a sticky change event is raised. When no steady pair appears for a long stretch of frames, a protection-switching byte failure is flagged.

The same K2 byte also carries the line alarm code in bits 6 to 8. Bit 1 is the MSB, so this code is K2[2:0]. Two alarm filters with hysteresis watch that code. One declares line AIS on code 111 and the other declares line RDI on code 110. Each alarm is declared after a run of matching frames and cleared after a run of frames that do not match.

A single interrupt line combines the sticky APS change event with a sticky AIS-declared event. The AIS part can be masked. A one-cycle clear pulse clears both sticky events.

Top module: `aps_line_monitor`

## Requirements
- R1: After synchronous reset, both latched bytes read 00h, and the failure flag, the AIS status, the RDI status, the change flag and the interrupt are all 0.
- R2: A K1/K2 pair is accepted only on the third consecutive strobed frame that carries it unchanged. A different pair restarts the run at one. When an accepted pair differs from the stored pair, the stored pair takes the new value in the cycle after that strobe.
- R3: The change flag sets in the cycle after a strobe that accepts a pair differing from the stored pair. Re-accepting the stored value, or a run that continues past three frames, does not set it.
- R4: The failure flag sets after the twelfth consecutive strobed frame in which the pair run is below three. It clears in the cycle after the strobe on which a run reaches three. The run counters saturate and do not wrap.
- R5: Line AIS is declared after 5 consecutive strobed frames with K2[2:0] = 111. Once declared, it is cleared after 5 consecutive strobed frames with any other code. A frame that agrees with the current state restarts the count.
- R6: Line RDI is declared after 5 consecutive strobed frames with K2[2:0] = 110. It is cleared after 5 consecutive strobed frames with any other code, using the same restart rule as R5.
- R7: The change flag and the AIS event are sticky. A clear pulse removes them. If a set and a clear happen in the same cycle, the set wins.
- R8: The interrupt is the change flag ORed with the AIS event, and the AIS event counts only while the AIS interrupt enable is 1. The AIS event is set by each new line AIS declaration.
- R9: In cycles without a frame strobe, the latched bytes, the failure flag and both alarm states hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe, once per received frame |
| k1_in | input | 8 | Received K1 byte, valid with frame_vld |
| k2_in | input | 8 | Received K2 byte, valid with frame_vld; alarm code in [2:0] |
| ais_irq_en | input | 1 | Lets the AIS event reach the interrupt |
| irq_clr | input | 1 | One-cycle pulse that clears the sticky events |
| k1_lat | output | 8 | Last accepted K1 |
| k2_lat | output | 8 | Last accepted K2 |
| aps_fail | output | 1 | Protection-switching byte failure |
| ais_l | output | 1 | Line AIS status |
| rdi_l | output | 1 | Line RDI status |
| aps_chg | output | 1 | Sticky APS change flag |
| irq | output | 1 | Interrupt |

## Verification
The embedded assertions check, on every cycle, the following:
- The stored pair changes only right after a strobe, and only to the pair that was strobed.
- The alarm states and the failure flag move only on strobes.
- A set always beats a same-cycle clear on the sticky flags.

The exact frame counts behind acceptance, failure, declaration and clearing can be shown only by the bench scenarios. The same applies to the restart of a run on a changed pattern and to the masking of AIS from the interrupt. The bench compares every strobe against a frame-level model under random runs of pairs, and adds directed runs that stop one frame short of each threshold.

// File: rtl/aps_mon_pkg.sv
// Package: shared types and default limits for the line APS monitor.
// Assumes: K2 alarm code sits in K2[2:0] (bit 8 = LSB in MSB-first numbering).
package aps_mon_pkg;
    typedef struct packed {
        logic [7:0] k1;
        logic [7:0] k2;
    } aps_pair_t;

    localparam int unsigned DEF_PAIR_RUN  = 3;
    localparam int unsigned DEF_FAIL_LIM  = 12;
    localparam int unsigned DEF_ALARM_RUN = 5;
    localparam int unsigned NUM_ALARMS    = 2;
    localparam logic [2:0]  CODE_AIS      = 3'b111;
    localparam logic [2:0]  CODE_RDI      = 3'b110;
endpackage

// File: rtl/aps_pair_filter.sv
// Module: persistence filter for the K1/K2 pair.
// Holds a candidate pair and counts how many strobed frames in a row it has
// repeated. On the strobe where the run reaches PAIR_RUN the pair is accepted.
// An accepted pair that differs from the stored one replaces it and pulses
// chg_evt_o. A stretch of FAIL_LIM strobes with no steady run raises fail_o.
// Assumes: frame_vld is a single-cycle strobe; the run counters saturate.
module aps_pair_filter
    import aps_mon_pkg::*;
#(
    parameter int unsigned PAIR_RUN = DEF_PAIR_RUN,
    parameter int unsigned FAIL_LIM = DEF_FAIL_LIM
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_vld,
    input  aps_pair_t pair_i,
    output aps_pair_t lat_o,
    output logic      chg_evt_o,
    output logic      fail_o
);
    localparam int unsigned RW = $clog2(PAIR_RUN + 1);
    localparam int unsigned FW = $clog2(FAIL_LIM + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(PAIR_RUN);
    localparam logic [RW-1:0] RUN_PRE = RW'(PAIR_RUN - 1);
    localparam logic [FW-1:0] FAIL_MAX = FW'(FAIL_LIM);
    localparam logic [FW-1:0] FAIL_PRE = FW'(FAIL_LIM - 1);

    aps_pair_t     cand_q;
    aps_pair_t     lat_q;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nxt;
    logic [FW-1:0] miss_q;
    logic          fail_q;
    logic          same_c;
    logic          accept_c;

    // Next run length: extend the run (saturating) on a repeat, else restart at one.
    always_comb begin
        same_c   = (pair_i == cand_q);
        run_nxt  = same_c ? ((run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1) : RW'(1);
        accept_c = frame_vld && same_c && (run_q == RUN_PRE);
    end

    // Candidate register and run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            run_q  <= '0;
        end else if (frame_vld) begin
            cand_q <= pair_i;
            run_q  <= run_nxt;
        end
    end

    // Stored pair: updated when an accepted pair differs from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (accept_c && (pair_i != lat_q)) begin
            lat_q <= pair_i;
        end
    end

    // Failure tracker: counts strobes without a steady run and flags at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= '0;
            fail_q <= 1'b0;
        end else if (frame_vld) begin
            if (run_nxt == RUN_MAX) begin
                miss_q <= '0;
                fail_q <= 1'b0;
            end else if (miss_q != FAIL_MAX) begin
                miss_q <= miss_q + 1'b1;
                if (miss_q == FAIL_PRE) begin
                    fail_q <= 1'b1;
                end
            end
        end
    end

    assign lat_o     = lat_q;
    assign chg_evt_o = accept_c && (pair_i != lat_q);
    assign fail_o    = fail_q;

    AST_LAT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lat_q != $past(lat_q))) |-> ($past(frame_vld) && ($past(pair_i) == lat_q))); // R2
    AST_FAIL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (fail_q != $past(fail_q))) |-> $past(frame_vld)); // R4
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q <= RUN_MAX) && (miss_q <= FAIL_MAX)); // R4
endmodule

// File: rtl/k2_alarm_filter.sv
// Module: hysteresis filter for one K2 alarm code.
// Declares the alarm after RUN strobed frames in a row that carry CODE in
// K2[2:0], and clears it after RUN strobed frames in a row that carry any other code.
// A frame that agrees with the current state restarts the count.
// Assumes: frame_vld is a single-cycle strobe.
module k2_alarm_filter #(
    parameter logic [2:0]  CODE = 3'b111,
    parameter int unsigned RUN  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [2:0] code_i,
    output logic       det_o,
    output logic       declare_o
);
    localparam int unsigned CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] CNT_PRE = CW'(RUN - 1);

    logic          det_q;
    logic [CW-1:0] cnt_q;
    logic          hit_c;

    assign hit_c = (code_i == CODE);

    // State and disagreement counter: toggle state after RUN contrary frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= 1'b0;
            cnt_q <= '0;
        end else if (frame_vld) begin
            if (hit_c != det_q) begin
                if (cnt_q == CNT_PRE) begin
                    det_q <= hit_c;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign det_o     = det_q;
    assign declare_o = frame_vld && hit_c && !det_q && (cnt_q == CNT_PRE);

    AST_ALARM_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(frame_vld)) |-> $stable(det_q)); // R9
    AST_DECLARE_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(det_q)) |-> ($past(code_i) == CODE)); // R5
    AST_CLEAR_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(det_q)) |-> ($past(code_i) != CODE)); // R6
endmodule

// File: rtl/sticky_event.sv
// Module: sticky event bit.
// Sets on set_i and clears on clr_i. When both arrive in the same cycle,
// the set wins.
module sticky_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    // Sticky register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else if (set_i) begin
            q_q <= 1'b1;
        end else if (clr_i) begin
            q_q <= 1'b0;
        end
    end

    assign q_o = q_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_i)) |-> q_q); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(set_i) && !$past(clr_i)) |-> $stable(q_q)); // R7
endmodule

// File: rtl/aps_line_monitor.sv
// Module: top of the line APS byte and K2 alarm monitor.
// Joins the pair persistence filter, one hysteresis filter per K2 alarm code
// (built by generate) and the sticky events that drive the interrupt.
// Assumes: the inputs come from an extractor in the same clock domain.
module aps_line_monitor
    import aps_mon_pkg::*;
#(
    parameter int unsigned PAIR_RUN  = DEF_PAIR_RUN,
    parameter int unsigned FAIL_LIM  = DEF_FAIL_LIM,
    parameter int unsigned ALARM_RUN = DEF_ALARM_RUN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [7:0] k1_in,
    input  logic [7:0] k2_in,
    input  logic       ais_irq_en,
    input  logic       irq_clr,
    output logic [7:0] k1_lat,
    output logic [7:0] k2_lat,
    output logic       aps_fail,
    output logic       ais_l,
    output logic       rdi_l,
    output logic       aps_chg,
    output logic       irq
);
    localparam logic [2:0] ALARM_CODE [NUM_ALARMS] = '{CODE_AIS, CODE_RDI};

    aps_pair_t             pair_c;
    aps_pair_t             lat_c;
    logic                  chg_evt;
    logic [NUM_ALARMS-1:0] alm_det;
    logic [NUM_ALARMS-1:0] alm_decl;
    logic                  ais_evt_q;

    assign pair_c.k1 = k1_in;
    assign pair_c.k2 = k2_in;

    aps_pair_filter #(
        .PAIR_RUN (PAIR_RUN),
        .FAIL_LIM (FAIL_LIM)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .pair_i    (pair_c),
        .lat_o     (lat_c),
        .chg_evt_o (chg_evt),
        .fail_o    (aps_fail)
    );

    for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_alarm
        k2_alarm_filter #(
            .CODE (ALARM_CODE[gi]),
            .RUN  (ALARM_RUN)
        ) u_alm (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_vld (frame_vld),
            .code_i    (k2_in[2:0]),
            .det_o     (alm_det[gi]),
            .declare_o (alm_decl[gi])
        );
    end

    sticky_event u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (chg_evt),
        .clr_i (irq_clr),
        .q_o   (aps_chg)
    );

    sticky_event u_ais (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (alm_decl[0]),
        .clr_i (irq_clr),
        .q_o   (ais_evt_q)
    );

    assign k1_lat = lat_c.k1;
    assign k2_lat = lat_c.k2;
    assign ais_l  = alm_det[0];
    assign rdi_l  = alm_det[1];
    assign irq    = aps_chg | (ais_evt_q & ais_irq_en);

    AST_CHG_NEEDS_NEW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(aps_chg)) |-> ($past(lat_c) != lat_c)); // R3
    AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !aps_chg) |-> ais_irq_en); // R8
endmodule

// File: tb/sim_aps_line_monitor.sv
module sim_aps_line_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [7:0] k1_in = '0;
    logic [7:0] k2_in = '0;
    logic       ais_irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] k1_lat, k2_lat;
    logic       aps_fail, ais_l, rdi_l, aps_chg, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Frame-level reference state
    logic [15:0] m_cand, m_lat;
    int          m_run, m_miss;
    bit          m_fail, m_ais, m_rdi, m_chg, m_aisev;
    int          m_ais_cnt, m_rdi_cnt;

    always #10 clk = ~clk;

    aps_line_monitor u0 (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .k1_in(k1_in), .k2_in(k2_in),
        .ais_irq_en(ais_irq_en), .irq_clr(irq_clr), .k1_lat(k1_lat), .k2_lat(k2_lat),
        .aps_fail(aps_fail), .ais_l(ais_l), .rdi_l(rdi_l), .aps_chg(aps_chg), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void m_reset();
        m_cand = '0; m_lat = '0; m_run = 0; m_miss = 0;
        m_fail = 0; m_ais = 0; m_rdi = 0; m_chg = 0; m_aisev = 0;
        m_ais_cnt = 0; m_rdi_cnt = 0;
    endfunction

    // Hysteresis step shared by both alarm codes: returns 1 on a new declaration
    function automatic bit m_alarm(inout bit st, inout int cnt, input bit hit);
        bit decl = 0;
        if (hit != st) begin
            if (cnt == 4) begin
                decl = hit;
                st = hit;
                cnt = 0;
            end else cnt++;
        end else cnt = 0;
        return decl;
    endfunction

    function automatic void m_step(input bit fv, input logic [15:0] p, input bit clr);
        bit set_chg = 0, set_ais = 0;
        if (fv) begin
            bit acc;
            if (p == m_cand) begin
                acc = (m_run == 2);
                if (m_run < 3) m_run++;
            end else begin
                acc = 0;
                m_run = 1;
                m_cand = p;
            end
            if (acc && p != m_lat) begin
                m_lat = p;
                set_chg = 1;
            end
            if (m_run == 3) begin
                m_miss = 0; m_fail = 0;
            end else if (m_miss < 12) begin
                m_miss++;
                if (m_miss == 12) m_fail = 1;
            end
            set_ais = m_alarm(m_ais, m_ais_cnt, p[2:0] == 3'b111);
            void'(m_alarm(m_rdi, m_rdi_cnt, p[2:0] == 3'b110));
        end
        m_chg   = set_chg ? 1'b1 : (clr ? 1'b0 : m_chg);
        m_aisev = set_ais ? 1'b1 : (clr ? 1'b0 : m_aisev);
    endfunction

    task automatic compare_all();
        chk("R2 k1_lat", k1_lat, m_lat[15:8]);
        chk("R2 k2_lat", k2_lat, m_lat[7:0]);
        chk("R4 aps_fail", aps_fail, m_fail);
        chk("R5 ais_l", ais_l, m_ais);
        chk("R6 rdi_l", rdi_l, m_rdi);
        chk("R3 aps_chg", aps_chg, m_chg);
        chk("R8 irq", irq, m_chg | (m_aisev & ais_irq_en));
    endtask

    // One cycle: drive at a negedge, sample at the following negedge.
    task automatic cyc(input bit fv, input logic [15:0] p, input bit clr);
        frame_vld = fv; k1_in = p[15:8]; k2_in = p[7:0]; irq_clr = clr;
        @(negedge clk);
        frame_vld = 0; irq_clr = 0;
        m_step(fv, p, clr);
        compare_all();
    endtask

    task automatic frames(input logic [15:0] p, input int n);
        for (int i = 0; i < n; i++) cyc(1, p, 0);
    endtask

    initial begin
        logic [15:0] pool [4];
        int cur;
        void'($urandom(32'd5150));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 k1_lat", k1_lat, 0); chk("R1 k2_lat", k2_lat, 0);
        chk("R1 fail", aps_fail, 0); chk("R1 ais", ais_l, 0);
        chk("R1 rdi", rdi_l, 0); chk("R1 chg", aps_chg, 0); chk("R1 irq", irq, 0);

        // R2/R3: two frames are not enough, third accepts
        frames(16'h5A01, 2);
        chk("R2 not yet after 2", k1_lat, 8'h00);
        frames(16'h5A01, 1);
        chk("R2 accepted on 3rd", k1_lat, 8'h5A);
        chk("R3 change flag", aps_chg, 1);
        // R7: a clear alone removes the flag; set beats a same-cycle clear
        cyc(0, 16'h0, 1);
        chk("R7 cleared", aps_chg, 0);
        frames(16'h3C02, 2);
        cyc(1, 16'h3C02, 1);
        chk("R7 set wins over clear", aps_chg, 1);
        cyc(0, 16'h0, 1);
        // R3: a longer run does not re-raise the flag
        frames(16'h3C02, 4);
        chk("R3 no re-raise", aps_chg, 0);
        // R9: idle cycles hold state
        for (int i = 0; i < 5; i++) cyc(0, 16'h0, 0);
        chk("R9 hold k1", k1_lat, 8'h3C);

        // R4: alternating pairs never form a run of three
        for (int i = 0; i < 11; i++) cyc(1, (i % 2) ? 16'h1111 : 16'h2222, 0);
        chk("R4 not after 11", aps_fail, 0);
        cyc(1, 16'h1111, 0);
        chk("R4 set after 12", aps_fail, 1);
        frames(16'h1111, 2);
        chk("R4 clears on run of 3", aps_fail, 0);
        cyc(0, 16'h0, 1);

        // R5/R8: AIS with mask off then on
        ais_irq_en = 0;
        frames(16'h0007, 4);
        chk("R5 not after 4", ais_l, 0);
        cyc(1, 16'h0007, 0);
        chk("R5 declared after 5", ais_l, 1);
        chk("R8 masked", irq, m_chg);
        cyc(0, 16'h0, 1);
        ais_irq_en = 1;
        // restart rule: 4 non-111 then a 111 restarts the clear count
        frames(16'h0005, 4);
        cyc(1, 16'h0007, 0);
        frames(16'h0005, 4);
        chk("R5 still set after restart", ais_l, 1);
        cyc(1, 16'h0005, 0);
        chk("R5 cleared after 5", ais_l, 0);
        frames(16'h0007, 5);
        chk("R8 unmasked AIS irq", irq, 1);
        cyc(0, 16'h0, 1);

        // R6: RDI declare and clear
        frames(16'h0006, 5);
        chk("R6 declared", rdi_l, 1);
        frames(16'h0003, 5);
        chk("R6 cleared", rdi_l, 0);

        // Random runs of pairs
        pool[0] = 16'hA507; pool[1] = 16'h4C06; pool[2] = 16'h9902; pool[3] = 16'h4C07;
        cur = 0;
        for (int i = 0; i < 2000; i++) begin
            if (($urandom % 4) == 0) cur = $urandom % 4;
            ais_irq_en = ($urandom % 8) != 0;
            cyc(($urandom % 6) != 0, pool[cur], ($urandom % 10) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule